// File: doc/BRIEF.md
# Inter-Processor Doorbell Controller

This block lets any processor in a small multicore cluster ring another processor and hand it a short message. Every processor owns a pair of 32-bit registers in a small memory-mapped window: a command register that it writes and a mailbox register that records the last doorbell it received. Writing the command register with the ring bit set makes a mailbox entry at the chosen target. The entry holds the sender's index and a 16-bit payload, and it raises that target's level interrupt. Writing the command register with the clear bit set drops the writer's own interrupt.

The register bus is a plain single-cycle port: `wr_i`/`rd_i` strobes, a byte address and 32-bit write data. Read data is combinational and valid in the same cycle as `rd_i`. Only one access happens per cycle, so at most one doorbell is raised and at most one is cleared in any cycle. There is no queue. A new doorbell to a processor replaces whatever its mailbox held.

Top module: `ipi_ctrl`

## Requirements
- R1: Byte address bit 2 selects the command register (0) or the mailbox register (1). Address bits from bit 3 upward select the processor index. An index at or above `N_CPU` reads as zero, and a write to it changes no register and no interrupt.
- R2: A write to a command address stores the full 32-bit word there. A read of that address returns it unchanged.
- R3: A command write with bit 30 (ring) set and target field bits 29:16 below `N_CPU` loads the target's mailbox with a new value. Bit 31 becomes 0 and bit 30 (pending) becomes 1. Bits 29:16 become the writer's index and bits 15:0 become bits 15:0 of the written word.
- R4: `irq_o[k]` always equals mailbox bit 30 of processor k. It rises on the clock edge that takes the ring write, and it never rises without a write.
- R5: A command write with bit 31 (clear) set clears the pending bit of the writer's own mailbox and lowers its interrupt. Bits 29:0 of that mailbox keep their values.
- R6: A write that sets both ring and clear and targets the writer itself updates the source and payload fields, but it leaves pending at 0 and the interrupt low.
- R7: A ring write whose target field is at or above `N_CPU` changes no mailbox and no interrupt. The command word is still stored.
- R8: Writes to mailbox addresses are ignored. No mailbox and no interrupt changes.
- R9: After reset, all command and mailbox registers read zero and all interrupts are low.
- R10: A ring to a processor whose doorbell is already pending overwrites the source and payload, and pending stays 1.
- R11: A write that rings another processor and clears the writer's own doorbell does both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when no read |
| irq_o | output | N_CPU | Level interrupt, one per processor |

## Verification
The checker watches the interrupt vector on every cycle. A legal ring must raise the target's line on the next edge. A clear must lower the writer's line, and clear wins over ring to self. A mailbox write or a ring to a missing target must leave all lines still, and no line may rise without a write. The exact contents of the registers can only be shown by the bench's scenarios, because they are visible only through bus reads. Those contents are the stored command word, the source index and payload in a mailbox, fields kept across a clear, overwrite without a queue, and zero reads from unpopulated indices. The bench follows every write with a full readback compared against its own model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ID_W    = 14;
  localparam int unsigned PAY_W   = 16;
  localparam int unsigned CLR_BIT = 31;
  localparam int unsigned RING_BIT = 30;

  typedef struct packed {
    logic             clr;
    logic             ring;
    logic [ID_W-1:0]  dst;
    logic [PAY_W-1:0] payload;
  } cmd_t;

  typedef struct packed {
    logic             rsvd;
    logic             pend;
    logic [ID_W-1:0]  src;
    logic [PAY_W-1:0] payload;
  } mbox_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [N_CPU-1:0]  cmd_we_o,
  output logic [N_CPU-1:0]  ring_hit_o,
  output logic [N_CPU-1:0]  clr_hit_o,
  output logic [ID_W-1:0]   src_id_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] cpu_idx;
  logic             idx_ok;
  logic             cmd_wr;
  logic             dst_ok;
  cmd_t             cmd;
  logic             unused_addr;

  assign cpu_idx     = addr_i[ADDR_W-1:3];
  assign unused_addr = ^addr_i[1:0];
  assign cmd         = cmd_t'(wdata_i);
  assign idx_ok      = 32'(cpu_idx) < N_CPU;
  assign dst_ok      = 32'(cmd.dst) < N_CPU;
  assign cmd_wr      = wr_i && !addr_i[2] && idx_ok;
  assign src_id_o    = ID_W'(cpu_idx);

  for (genvar k = 0; k < N_CPU; k++) begin : g_dec
    assign cmd_we_o[k]   = cmd_wr && (cpu_idx == IDX_W'(k));
    assign clr_hit_o[k]  = cmd_wr && cmd.clr && (cpu_idx == IDX_W'(k));
    assign ring_hit_o[k] = cmd_wr && cmd.ring && dst_ok && (cmd.dst == ID_W'(k));
  end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              ring_hit_i,
  input  logic              clr_hit_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ID_W-1:0]   src_id_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] mbox_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] cmd_q;
  mbox_t             mbox_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else if (cmd_we_i) cmd_q <= wdata_i;
  end

  // ring lands first; a clear in the same cycle overrides pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbox_q <= '0;
    end else begin
      if (ring_hit_i) begin
        mbox_q.rsvd    <= 1'b0;
        mbox_q.pend    <= 1'b1;
        mbox_q.src     <= src_id_i;
        mbox_q.payload <= wdata_i[PAY_W-1:0];
      end
      if (clr_hit_i) mbox_q.pend <= 1'b0;
    end
  end

  assign cmd_o  = cmd_q;
  assign mbox_o = mbox_q;
  assign irq_o  = mbox_q.pend;
endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] cmd_i  [N_CPU],
  input  logic [WORD_W-1:0] mbox_i [N_CPU],
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] cpu_idx;
  assign cpu_idx = addr_i[ADDR_W-1:3];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      for (int k = 0; k < N_CPU; k++) begin
        if (cpu_idx == IDX_W'(k)) rdata_o = addr_i[2] ? mbox_i[k] : cmd_i[k];
      end
    end
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CPU-1:0]  irq_o
);
  logic [N_CPU-1:0]  cmd_we, ring_hit, clr_hit;
  logic [ID_W-1:0]   src_id;
  logic [WORD_W-1:0] cmd_r  [N_CPU];
  logic [WORD_W-1:0] mbox_r [N_CPU];

  ipi_decode #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) i_decode (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cmd_we_o  (cmd_we),
    .ring_hit_o(ring_hit),
    .clr_hit_o (clr_hit),
    .src_id_o  (src_id)
  );

  for (genvar k = 0; k < N_CPU; k++) begin : g_slot
    ipi_slot i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_we_i  (cmd_we[k]),
      .ring_hit_i(ring_hit[k]),
      .clr_hit_i (clr_hit[k]),
      .wdata_i   (wdata_i),
      .src_id_i  (src_id),
      .cmd_o     (cmd_r[k]),
      .mbox_o    (mbox_r[k]),
      .irq_o     (irq_o[k])
    );
  end

  ipi_rd_mux #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) i_rd_mux (
    .rd_i   (rd_i),
    .addr_i (addr_i),
    .cmd_i  (cmd_r),
    .mbox_i (mbox_r),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [N_CPU-1:0]  irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] w_idx;
  logic             cmd_wr, dst_ok, unused_lo;
  assign w_idx     = addr_i[ADDR_W-1:3];
  assign unused_lo = ^addr_i[1:0];
  assign cmd_wr    = wr_i && !addr_i[2] && (32'(w_idx) < N_CPU);
  assign dst_ok    = 32'(wdata_i[29:16]) < N_CPU;

  for (genvar k = 0; k < N_CPU; k++) begin : g_chk
    p_ring_raises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_wr && wdata_i[30] && dst_ok && (wdata_i[29:16] == 14'(k)) &&
      !(wdata_i[31] && w_idx == IDX_W'(k)) |=> irq_o[k]);

    p_clear_lowers_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_wr && wdata_i[31] && (w_idx == IDX_W'(k)) |=> !irq_o[k]);

    p_no_rise_unwritten_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[k]) |-> $past(wr_i));
  end

  p_mbox_write_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i[2] |=> $stable(irq_o));

  p_bad_target_dropped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i[30] && !dst_ok && !wdata_i[31] |=> $stable(irq_o));
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o)
);

// File: tb/test_ipi_ctrl.sv
module test_ipi_ctrl;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  logic [31:0] cmd_m [N];
  logic [31:0] mbox_m [N];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_ctrl #(.N_CPU(N), .ADDR_W(AW)) i_ipi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(bit clr, bit ring, int dst, logic [15:0] pay);
    return {clr, ring, 14'(dst), pay};
  endfunction

  function automatic void model_wr(logic [AW-1:0] a, logic [31:0] d);
    int w = int'(a[AW-1:3]);
    int dst = int'(d[29:16]);
    if (w >= N || a[2]) return;
    cmd_m[w] = d;
    if (d[30] && dst < N) mbox_m[dst] = {2'b01, 14'(w), d[15:0]};
    if (d[31]) mbox_m[w][30] = 1'b0;
  endfunction

  function automatic logic [31:0] irq_exp();
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = mbox_m[i][30];
    return v;
  endfunction

  task automatic do_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
    addr = a; rd = 1'b1;
    #1;
    chk(req, rdata, exp);
    rd = 1'b0;
    #1;
  endtask

  // called right after a negedge, before the next posedge
  task automatic check_all(string rc, string rm, string ri);
    chk(ri, 32'(irq), irq_exp());
    for (int i = 0; i < N; i++) begin
      rd_chk(rc, AW'(i * 8), cmd_m[i]);
      rd_chk(rm, AW'(i * 8 + 4), mbox_m[i]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) begin cmd_m[i] = '0; mbox_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 cmd reset", "R9 mbox reset", "R9 irq reset");

    // R2: verbatim store
    do_wr(AW'(8), 32'h0123_abcd);
    check_all("R2 cmd store", "R2 mbox", "R2 irq");
    // R3/R4: ring cpu2 from cpu1
    do_wr(AW'(8), cmd_word(0, 1, 2, 16'hbeef));
    chk("R4 irq rise next edge", 32'(irq), 32'h4);
    check_all("R3 cmd", "R3 mbox fields", "R4 irq");
    // R10: overwrite while pending, from cpu3
    do_wr(AW'(24), cmd_word(0, 1, 2, 16'h5a5a));
    check_all("R10 cmd", "R10 mbox overwrite", "R10 irq");
    // R5: cpu2 clears, fields kept
    do_wr(AW'(16), cmd_word(1, 0, 0, 16'h0));
    chk("R5 irq lowered", 32'(irq), 32'h0);
    check_all("R5 cmd", "R5 fields kept", "R5 irq");
    // R6: ring+clear to self
    do_wr(AW'(0), cmd_word(1, 1, 0, 16'h7777));
    chk("R6 irq stays low", 32'(irq), 32'h0);
    check_all("R6 cmd", "R6 mbox", "R6 irq");
    // R11: cpu0 rings cpu3 and clears self
    do_wr(AW'(0), cmd_word(0, 1, 0, 16'h1111));
    do_wr(AW'(0), cmd_word(1, 1, 3, 16'h2222));
    check_all("R11 cmd", "R11 mbox", "R11 irq");
    // R7: target out of range
    do_wr(AW'(8), cmd_word(0, 1, N, 16'h9999));
    check_all("R7 cmd stored", "R7 mbox unchanged", "R7 irq unchanged");
    // R8: mailbox write ignored
    do_wr(AW'(3 * 8 + 4), 32'h0000_0000);
    do_wr(AW'(1 * 8 + 4), 32'hffff_ffff);
    check_all("R8 cmd", "R8 mbox unchanged", "R8 irq unchanged");
    // R1: unpopulated index
    do_wr(AW'(N * 8), cmd_word(1, 1, 3, 16'hdead));
    check_all("R1 cmd", "R1 mbox", "R1 irq");
    @(negedge clk);
    rd_chk("R1 unpopulated reads zero", AW'(N * 8), 32'h0);
    rd_chk("R1 unpopulated mbox zero", AW'(N * 8 + 4), 32'h0);
    rd_chk("R1 bit2 selects mbox", AW'(3 * 8 + 6), mbox_m[3]);

    for (int t = 0; t < 400; t++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      a = AW'(($urandom % (N + 1)) * 8 + ($urandom % 8));
      d = cmd_word(($urandom % 4) == 0, ($urandom % 2) == 0,
                   int'($urandom % (N + 2)), 16'($urandom));
      if (($urandom % 16) == 0) d = $urandom;
      do_wr(a, d);
      check_all("R2 random cmd", "R3 random mbox", "R4 random irq");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule